// File: doc/BRIEF.md
# Register Use-Def Hazard and Forwarding Unit

This unit tracks which in-flight instructions still owe a result to each integer register of an in-order pipeline. It decides, one command per cycle, whether a source operand can be read from the register file or forwarded from an older producer, or whether the instruction must stall. It also decides whether a result may be committed. Instructions are named by a wrapping age tag. Each register keeps a short list of pending writer tags, oldest first, and a slot for each writer's result once it is captured.

Three commands come in on one port. A mark command places the issuing instruction on the pending list of every register in a destination mask. A read command returns a source operand. A write command commits a value, but only for the writer at the head of that register's list; that entry then leaves the list. A separate capture port records a producer's result against its tag, so that younger readers can take the value before it is committed. A flush clears every list and every captured result and leaves the register file as it is.

Every command gets a registered response one cycle later. The response is a small state machine whose state is the outcome kind: RK_IDLE (no command), RK_FILE (read served by the register file), RK_FWD (read served by forwarding), RK_ZERO (access to register 0), RK_STALL (not done, retry), RK_MARK (mark accepted) and RK_WRITE (write committed). Each cycle the next state is chosen by the decoded command and the tracking state of the addressed register. A flush forces the next state to RK_IDLE. Any state can move to any other state.

Top module: `udu_core`

## Requirements
- R1: After reset, rsp_valid is 0, all three counters are 0, no register has a pending writer, and every register reads 0.
- R2: cmd_op encodes 0 nop, 1 mark, 2 read and 3 write. A non-nop command sampled at a clock edge with flush low gives rsp_valid high for exactly the following cycle. rsp_kind codes are idle 0, file 1, forward 2, zero 3, stall 4, mark 5 and write 6. rsp_done is high for every kind except idle and stall.
- R3: A read of register 0 returns kind 3 with data 0. It performs no dependency check and changes no counter.
- R4: A write to register 0 returns kind 3 and has no effect. Register 0 still reads 0 afterwards.
- R5: A read whose register has no pending writer older than the reader returns kind 1 with the register-file value, and rd_count increases by one.
- R6: If an older pending writer exists and the youngest such writer has a captured result, a read returns kind 2 with that result, and fwd_count increases by one.
- R7: If the youngest older pending writer has no captured result, a read returns kind 4 (stall) with data 0.
- R8: A write succeeds only when its tag equals the oldest pending writer of that register. It then stores the data, removes that entry, returns kind 6 and increments wr_count. Otherwise it returns kind 4 and changes nothing.
- R9: A mark appends its tag to the list of every register whose cmd_mask bit is set (bit 0 is ignored) and returns kind 5. If any of those lists already holds DEPTH entries, the mark returns kind 4 and appends to no list.
- R10: Tag a is older than tag b when bit TAG_W-1 of (a - b) modulo 2^TAG_W is set, so age ordering survives tag wrap-around.
- R11: Flush empties all pending lists and captured results at the next edge and leaves register contents intact. A command sampled together with flush is discarded and gets no response.
- R12: A capture records its data for every pending entry with a matching tag. The result is visible to commands from the following cycle, and a capture alone produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all tracking state, discard same-cycle command |
| cmd_op | input | 2 | Command: 0 nop, 1 mark, 2 read, 3 write |
| cmd_tag | input | TAG_W | Age tag of the issuing instruction |
| cmd_reg | input | $clog2(NREG) | Register index for read and write |
| cmd_mask | input | NREG | Destination mask for mark |
| cmd_data | input | XLEN | Write data |
| cap_valid | input | 1 | Producer result capture strobe |
| cap_tag | input | TAG_W | Tag of the producer whose result is captured |
| cap_data | input | XLEN | Captured result value |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_done | output | 1 | Command completed (not stalled) |
| rsp_kind | output | 3 | Outcome kind code |
| rsp_data | output | XLEN | Read operand, 0 for other kinds |
| fwd_count | output | CNT_W | Number of forwarded reads |
| rd_count | output | CNT_W | Number of register-file reads |
| wr_count | output | CNT_W | Number of register-file writes |

## Verification
On every cycle the assertions check several invariants. Each pending list stays packed from its head. No list is pushed when full, and no list is popped when empty. Register 0 is never written. Responses appear only one cycle after an accepted command. A zero-register response carries zero data. The forward and write counters step exactly with their response kinds. After a flush no pending writer is left. Only the bench's scenarios can show that the correct operand reaches the reader: file versus forward versus stall, and the right one among several older writers. They also show that out-of-order writes are refused, that a refused mark leaves no partial insertion, that tag wrap-around orders ages correctly, and that the register file survives a flush.

// File: rtl/udu_pkg.sv
package udu_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_MARK  = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } udu_op_e;

    typedef enum logic [2:0] {
        RK_IDLE  = 3'd0,
        RK_FILE  = 3'd1,
        RK_FWD   = 3'd2,
        RK_ZERO  = 3'd3,
        RK_STALL = 3'd4,
        RK_MARK  = 3'd5,
        RK_WRITE = 3'd6
    } udu_rsp_e;

endpackage

// File: rtl/udu_regfile.sv
module udu_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [AW-1:0]   raddr_i,
    output logic [XLEN-1:0] rdata_o
);

    logic [XLEN-1:0] mem_q [NREG];

    // register 0 has no storage: it is tied to zero
    assign mem_q[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we_i && waddr_i == AW'(g)) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R4
    zero_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> waddr_i != '0);

endmodule

// File: rtl/udu_wlist.sv
module udu_wlist #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    parameter int XLEN  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         push_i,
    input  logic [TAG_W-1:0]             push_tag_i,
    input  logic                         pop_i,
    input  logic                         cap_valid_i,
    input  logic [TAG_W-1:0]             cap_tag_i,
    input  logic [XLEN-1:0]              cap_data_i,
    output logic [DEPTH-1:0]             vld_o,
    output logic [DEPTH-1:0][TAG_W-1:0]  tag_o,
    output logic [DEPTH-1:0]             have_o,
    output logic [DEPTH-1:0][XLEN-1:0]   data_o,
    output logic                         full_o
);

    logic [DEPTH-1:0]            v_q, v_n, h_q, h_n;
    logic [DEPTH-1:0][TAG_W-1:0] t_q, t_n;
    logic [DEPTH-1:0][XLEN-1:0]  d_q, d_n;
    logic                        placed;

    always_comb begin
        v_n    = v_q;
        h_n    = h_q;
        t_n    = t_q;
        d_n    = d_q;
        placed = 1'b0;
        // capture first, so an entry popped this cycle carries nothing stale
        for (int i = 0; i < DEPTH; i++) begin
            if (cap_valid_i && v_q[i] && t_q[i] == cap_tag_i) begin
                h_n[i] = 1'b1;
                d_n[i] = cap_data_i;
            end
        end
        if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                v_n[i] = v_n[i+1];
                h_n[i] = h_n[i+1];
                t_n[i] = t_n[i+1];
                d_n[i] = d_n[i+1];
            end
            v_n[DEPTH-1] = 1'b0;
            h_n[DEPTH-1] = 1'b0;
            t_n[DEPTH-1] = '0;
            d_n[DEPTH-1] = '0;
        end
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !v_n[i]) begin
                    v_n[i] = 1'b1;
                    h_n[i] = 1'b0;
                    t_n[i] = push_tag_i;
                    d_n[i] = '0;
                    placed = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
            h_q <= '0;
            t_q <= '0;
            d_q <= '0;
        end else if (flush_i) begin
            v_q <= '0;
            h_q <= '0;
            t_q <= '0;
            d_q <= '0;
        end else begin
            v_q <= v_n;
            h_q <= h_n;
            t_q <= t_n;
            d_q <= d_n;
        end
    end

    assign vld_o  = v_q;
    assign tag_o  = t_q;
    assign have_o = h_q;
    assign data_o = d_q;
    assign full_o = &v_q;

    // R9
    pend_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((v_q + 1'b1) & v_q) == '0);

    // R9
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R8
    pop_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> v_q[0]);

endmodule

// File: rtl/udu_lookup.sv
module udu_lookup #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    parameter int XLEN  = 32
) (
    input  logic [DEPTH-1:0]            vld_i,
    input  logic [DEPTH-1:0][TAG_W-1:0] tag_i,
    input  logic [DEPTH-1:0]            have_i,
    input  logic [DEPTH-1:0][XLEN-1:0]  data_i,
    input  logic [TAG_W-1:0]            rd_tag_i,
    output logic                        older_o,
    output logic                        fwd_ok_o,
    output logic [XLEN-1:0]             fwd_data_o
);

    logic [DEPTH-1:0][TAG_W-1:0] diff;
    logic                        y_have;

    // entries are oldest first, so the last older entry found is the youngest
    always_comb begin
        older_o    = 1'b0;
        y_have     = 1'b0;
        fwd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            diff[i] = tag_i[i] - rd_tag_i;
            if (vld_i[i] && diff[i][TAG_W-1]) begin
                older_o    = 1'b1;
                y_have     = have_i[i];
                fwd_data_o = data_i[i];
            end
        end
        fwd_ok_o = older_o && y_have;
    end

endmodule

// File: rtl/udu_core.sv
module udu_core
    import udu_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    parameter int CNT_W = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       cmd_op,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic [AW-1:0]    cmd_reg,
    input  logic [NREG-1:0]  cmd_mask,
    input  logic [XLEN-1:0]  cmd_data,
    input  logic             cap_valid,
    input  logic [TAG_W-1:0] cap_tag,
    input  logic [XLEN-1:0]  cap_data,
    output logic             rsp_valid,
    output logic             rsp_done,
    output logic [2:0]       rsp_kind,
    output logic [XLEN-1:0]  rsp_data,
    output logic [CNT_W-1:0] fwd_count,
    output logic [CNT_W-1:0] rd_count,
    output logic [CNT_W-1:0] wr_count
);

    logic [DEPTH-1:0]            wl_vld  [NREG];
    logic [DEPTH-1:0][TAG_W-1:0] wl_tag  [NREG];
    logic [DEPTH-1:0]            wl_have [NREG];
    logic [DEPTH-1:0][XLEN-1:0]  wl_data [NREG];
    logic [NREG-1:0]             full_vec, push_vec, pop_vec, busy_vec;

    logic            rf_we;
    logic [XLEN-1:0] rf_rdata;
    logic            lk_older, lk_fwd;
    logic [XLEN-1:0] lk_data;

    udu_rsp_e        state_q, state_n;
    logic [XLEN-1:0] data_q, data_n;
    logic [NREG-1:0] mark_mask;
    udu_op_e         op;
    logic            head_hit;

    for (genvar g = 0; g < NREG; g++) begin : g_list
        udu_wlist #(.DEPTH(DEPTH), .TAG_W(TAG_W), .XLEN(XLEN)) u_list (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush_i    (flush),
            .push_i     (push_vec[g]),
            .push_tag_i (cmd_tag),
            .pop_i      (pop_vec[g]),
            .cap_valid_i(cap_valid),
            .cap_tag_i  (cap_tag),
            .cap_data_i (cap_data),
            .vld_o      (wl_vld[g]),
            .tag_o      (wl_tag[g]),
            .have_o     (wl_have[g]),
            .data_o     (wl_data[g]),
            .full_o     (full_vec[g])
        );
        assign busy_vec[g] = |wl_vld[g];
    end

    udu_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (rf_we),
        .waddr_i(cmd_reg),
        .wdata_i(cmd_data),
        .raddr_i(cmd_reg),
        .rdata_o(rf_rdata)
    );

    udu_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W), .XLEN(XLEN)) u_lookup (
        .vld_i     (wl_vld[cmd_reg]),
        .tag_i     (wl_tag[cmd_reg]),
        .have_i    (wl_have[cmd_reg]),
        .data_i    (wl_data[cmd_reg]),
        .rd_tag_i  (cmd_tag),
        .older_o   (lk_older),
        .fwd_ok_o  (lk_fwd),
        .fwd_data_o(lk_data)
    );

    assign op        = udu_op_e'(cmd_op);
    assign mark_mask = cmd_mask & ~NREG'(1);
    assign head_hit  = wl_vld[cmd_reg][0] && wl_tag[cmd_reg][0] == cmd_tag;

    // next-state and side-effect decode
    always_comb begin
        state_n  = RK_IDLE;
        data_n   = '0;
        push_vec = '0;
        pop_vec  = '0;
        rf_we    = 1'b0;
        if (!flush) begin
            unique case (op)
                OP_NOP: state_n = RK_IDLE;
                OP_MARK: begin
                    if (|(mark_mask & full_vec)) begin
                        state_n = RK_STALL;
                    end else begin
                        push_vec = mark_mask;
                        state_n  = RK_MARK;
                    end
                end
                OP_READ: begin
                    if (cmd_reg == '0) begin
                        state_n = RK_ZERO;
                    end else if (!lk_older) begin
                        state_n = RK_FILE;
                        data_n  = rf_rdata;
                    end else if (lk_fwd) begin
                        state_n = RK_FWD;
                        data_n  = lk_data;
                    end else begin
                        state_n = RK_STALL;
                    end
                end
                OP_WRITE: begin
                    if (cmd_reg == '0) begin
                        state_n = RK_ZERO;
                    end else if (head_hit) begin
                        pop_vec[cmd_reg] = 1'b1;
                        rf_we            = 1'b1;
                        state_n          = RK_WRITE;
                    end else begin
                        state_n = RK_STALL;
                    end
                end
                default: state_n = RK_IDLE;
            endcase
        end
    end

    // state register with counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RK_IDLE;
            data_q    <= '0;
            fwd_count <= '0;
            rd_count  <= '0;
            wr_count  <= '0;
        end else begin
            state_q <= state_n;
            data_q  <= data_n;
            if (state_n == RK_FWD)   fwd_count <= fwd_count + 1'b1;
            if (state_n == RK_FILE)  rd_count  <= rd_count + 1'b1;
            if (state_n == RK_WRITE) wr_count  <= wr_count + 1'b1;
        end
    end

    // outputs from state
    always_comb begin
        rsp_valid = state_q != RK_IDLE;
        rsp_done  = rsp_valid && state_q != RK_STALL;
        rsp_kind  = state_q;
        rsp_data  = data_q;
    end

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(cmd_op) != 2'd0 && !$past(flush)));

    // R3
    zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_kind == 3'd3 |-> rsp_data == '0);

    // R6
    fwd_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_kind == 3'd2 |-> fwd_count == $past(fwd_count) + 1'b1);

    // R8
    wr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_kind == 3'd6 |-> wr_count == $past(wr_count) + 1'b1);

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> busy_vec == '0);

endmodule

// File: tb/tb_udu_core.sv
`timescale 1ns/1ps
module tb_udu_core;

    localparam int NREG = 32;
    localparam int XLEN = 32;
    localparam int TAG_W = 8;
    localparam int NV = 23;

    typedef struct packed {
        logic        cap;
        logic [1:0]  op;
        logic [7:0]  tag;
        logic [4:0]  rg;
        logic [31:0] mask;
        logic [31:0] data;
        logic [2:0]  kind;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd3, 8'd5,  5'd0, 32'h0, 32'h55,       3'd3, 32'h0},
        '{1'b0, 2'd2, 8'd5,  5'd0, 32'h0, 32'h0,        3'd3, 32'h0},
        '{1'b0, 2'd1, 8'd10, 5'd0, 32'h6, 32'h0,        3'd5, 32'h0},
        '{1'b0, 2'd2, 8'd11, 5'd1, 32'h0, 32'h0,        3'd4, 32'h0},
        '{1'b0, 2'd2, 8'd9,  5'd1, 32'h0, 32'h0,        3'd1, 32'h0},
        '{1'b1, 2'd0, 8'd10, 5'd0, 32'h0, 32'hAAAA0001, 3'd0, 32'h0},
        '{1'b0, 2'd2, 8'd11, 5'd2, 32'h0, 32'h0,        3'd2, 32'hAAAA0001},
        '{1'b0, 2'd3, 8'd12, 5'd1, 32'h0, 32'h99,       3'd4, 32'h0},
        '{1'b0, 2'd3, 8'd10, 5'd1, 32'h0, 32'h11111111, 3'd6, 32'h0},
        '{1'b0, 2'd2, 8'd11, 5'd1, 32'h0, 32'h0,        3'd1, 32'h11111111},
        '{1'b0, 2'd1, 8'd20, 5'd0, 32'h8, 32'h0,        3'd5, 32'h0},
        '{1'b0, 2'd1, 8'd21, 5'd0, 32'h8, 32'h0,        3'd5, 32'h0},
        '{1'b1, 2'd0, 8'd20, 5'd0, 32'h0, 32'h20,       3'd0, 32'h0},
        '{1'b0, 2'd2, 8'd22, 5'd3, 32'h0, 32'h0,        3'd4, 32'h0},
        '{1'b1, 2'd0, 8'd21, 5'd0, 32'h0, 32'h21,       3'd0, 32'h0},
        '{1'b0, 2'd2, 8'd22, 5'd3, 32'h0, 32'h0,        3'd2, 32'h21},
        '{1'b0, 2'd2, 8'd21, 5'd3, 32'h0, 32'h0,        3'd2, 32'h20},
        '{1'b0, 2'd3, 8'd21, 5'd3, 32'h0, 32'h3131,     3'd4, 32'h0},
        '{1'b0, 2'd3, 8'd20, 5'd3, 32'h0, 32'h3030,     3'd6, 32'h0},
        '{1'b0, 2'd3, 8'd21, 5'd3, 32'h0, 32'h3131,     3'd6, 32'h0},
        '{1'b0, 2'd2, 8'd22, 5'd3, 32'h0, 32'h0,        3'd1, 32'h3131},
        '{1'b0, 2'd3, 8'd10, 5'd2, 32'h0, 32'h2222,     3'd6, 32'h0},
        '{1'b0, 2'd2, 8'd30, 5'd2, 32'h0, 32'h0,        3'd1, 32'h2222}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic [1:0]       cmd_op = 2'd0;
    logic [TAG_W-1:0] cmd_tag = '0;
    logic [4:0]       cmd_reg = '0;
    logic [NREG-1:0]  cmd_mask = '0;
    logic [XLEN-1:0]  cmd_data = '0;
    logic             cap_valid = 1'b0;
    logic [TAG_W-1:0] cap_tag = '0;
    logic [XLEN-1:0]  cap_data = '0;
    logic             rsp_valid, rsp_done;
    logic [2:0]       rsp_kind;
    logic [XLEN-1:0]  rsp_data;
    logic [31:0]      fwd_count, rd_count, wr_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    udu_core dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cmd_op(cmd_op), .cmd_tag(cmd_tag), .cmd_reg(cmd_reg),
        .cmd_mask(cmd_mask), .cmd_data(cmd_data),
        .cap_valid(cap_valid), .cap_tag(cap_tag), .cap_data(cap_data),
        .rsp_valid(rsp_valid), .rsp_done(rsp_done), .rsp_kind(rsp_kind),
        .rsp_data(rsp_data), .fwd_count(fwd_count), .rd_count(rd_count),
        .wr_count(wr_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, response is visible at the next falling edge
    task automatic step(input logic cap, input logic [1:0] op, input logic [7:0] tag,
                        input logic [4:0] rg, input logic [31:0] mask, input logic [31:0] data);
        if (cap) begin
            cap_valid = 1'b1;
            cap_tag   = tag;
            cap_data  = data;
        end else begin
            cmd_op   = op;
            cmd_tag  = tag;
            cmd_reg  = rg;
            cmd_mask = mask;
            cmd_data = data;
        end
        @(negedge clk);
        cap_valid = 1'b0;
        cmd_op    = 2'd0;
    endtask

    task automatic expect_rsp(input string req, input logic [2:0] kind, input logic [31:0] exp);
        chk(rsp_kind == kind, req, "kind", 32'(rsp_kind), 32'(kind));
        chk(rsp_data == exp, req, "data", rsp_data, exp);
        chk(rsp_done == (kind != 3'd0 && kind != 3'd4), req, "done",
            32'(rsp_done), 32'(kind != 3'd0 && kind != 3'd4));
    endtask

    function automatic string req_of(input logic [2:0] k);
        case (k)
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R3";
            3'd4: return "R7";
            3'd5: return "R9";
            3'd6: return "R8";
            default: return "R12";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'h0);
        chk(fwd_count == 0 && rd_count == 0 && wr_count == 0, "R1", "counters",
            fwd_count | rd_count | wr_count, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after release", 32'(rsp_valid), 32'h0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R12
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].cap, VEC[i].op, VEC[i].tag, VEC[i].rg, VEC[i].mask, VEC[i].data);
            if (VEC[i].op == 2'd0)
                chk(rsp_valid == 1'b0, "R12", "capture gives no response", 32'(rsp_valid), 32'h0);
            else
                chk(rsp_valid == 1'b1, "R2", "rsp_valid", 32'(rsp_valid), 32'h1);
            expect_rsp(req_of(VEC[i].kind), VEC[i].kind, VEC[i].exp);
        end
        // R2: response lasts one cycle
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "response single cycle", 32'(rsp_valid), 32'h0);
        chk(rd_count == 4, "R5", "rd_count", rd_count, 32'd4);
        chk(fwd_count == 3, "R6", "fwd_count", fwd_count, 32'd3);
        chk(wr_count == 4, "R8", "wr_count", wr_count, 32'd4);

        // R4: zero register unaffected by the earlier write, no counter change
        step(1'b0, 2'd2, 8'd40, 5'd0, 32'h0, 32'h0);
        expect_rsp("R4", 3'd3, 32'h0);
        chk(rd_count == 4, "R3", "zero read not counted", rd_count, 32'd4);

        // R9: fill register 5, then a mark touching full reg 5 and empty reg 6
        for (int t = 40; t < 44; t++) begin
            step(1'b0, 2'd1, 8'(t), 5'd0, 32'h20, 32'h0);
            expect_rsp("R9", 3'd5, 32'h0);
        end
        step(1'b0, 2'd1, 8'd44, 5'd0, 32'h60, 32'h0);
        expect_rsp("R9", 3'd4, 32'h0);
        step(1'b0, 2'd2, 8'd45, 5'd6, 32'h0, 32'h0);
        expect_rsp("R9", 3'd1, 32'h0);
        step(1'b0, 2'd2, 8'd45, 5'd5, 32'h0, 32'h0);
        expect_rsp("R7", 3'd4, 32'h0);

        // R11: flush with a same-cycle command
        step(1'b1, 2'd0, 8'd43, 5'd0, 32'h0, 32'hDEAD);
        flush    = 1'b1;
        cmd_op   = 2'd2;
        cmd_tag  = 8'd45;
        cmd_reg  = 5'd5;
        @(negedge clk);
        flush  = 1'b0;
        cmd_op = 2'd0;
        chk(rsp_valid == 1'b0, "R11", "command with flush discarded", 32'(rsp_valid), 32'h0);
        step(1'b0, 2'd2, 8'd45, 5'd5, 32'h0, 32'h0);
        expect_rsp("R11", 3'd1, 32'h0);
        step(1'b0, 2'd2, 8'd99, 5'd2, 32'h0, 32'h0);
        expect_rsp("R11", 3'd1, 32'h2222);
        step(1'b0, 2'd2, 8'd99, 5'd3, 32'h0, 32'h0);
        expect_rsp("R11", 3'd1, 32'h3131);

        // R10: tag wrap-around, writer 250 is older than reader 3, younger than 249
        step(1'b0, 2'd1, 8'd250, 5'd0, 32'h80, 32'h0);
        expect_rsp("R10", 3'd5, 32'h0);
        step(1'b0, 2'd2, 8'd3, 5'd7, 32'h0, 32'h0);
        expect_rsp("R10", 3'd4, 32'h0);
        step(1'b0, 2'd2, 8'd249, 5'd7, 32'h0, 32'h0);
        expect_rsp("R10", 3'd1, 32'h0);

        chk(rd_count == 9, "R5", "final rd_count", rd_count, 32'd9);
        chk(fwd_count == 3, "R6", "final fwd_count", fwd_count, 32'd3);
        chk(wr_count == 4, "R8", "final wr_count", wr_count, 32'd4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule